// File: doc/BRIEF.md
# Six-Digit Time-of-Day Clock with Scanned Seven-Segment Output

This block keeps the time of day as six BCD digits (hours, minutes and seconds, 24-hour format) and shows it on a six-digit display whose segment lines are shared by all digits. A slow line-rate tick of nominally 50 Hz is the only time reference. A prescaler counts 50 of its rising edges to make a one-second event. That event advances the time counters and also appears on its own output pin. A rising edge on a separate sync input restarts the prescaler, so the seconds boundary can be lined up with an outside once-per-second reference without changing the displayed time.

The display side walks through the digits one at a time. It raises exactly one digit-enable line and puts that digit's segment pattern on the seven shared segment lines. Software-free time setting is done with a one-cycle load strobe that writes all six digits together and restarts the prescaler. All logic runs on a single system clock. The tick and sync inputs may be asynchronous to it, because each is synchronized and reduced to a one-cycle rising-edge event.

Top module: `tod_display_clock`

## Requirements
- R1: After every 50th rising edge of `tick_in`, counted since reset, the last load or the last sync edge, the time advances by exactly one second and `pps_out` is high for exactly one system-clock cycle. No other tick edge changes the time.
- R2: A rising edge on `sync_in` restarts the prescaler count at zero, so the next one-second advance comes exactly 50 tick edges later. A sync edge never changes the time digits, and it wins over a tick edge that is detected in the same cycle.
- R3: The units of seconds and the units of minutes count 0 to 9. The tens of seconds and the tens of minutes count 0 to 5. Every wrap carries one into the next higher digit, so xx:xx:59 becomes the next minute at :00 and xx:59:59 becomes the next hour at :00:00.
- R4: Hours count in 24-hour format. The units of hours wrap 9 to 0 and carry into the tens of hours (09 becomes 10), and 23:59:59 becomes 00:00:00.
- R5: When `load_valid` is high in a cycle, `load_time` is written to all six digits on that clock edge and the prescaler restarts at zero. The layout of `load_time` from bit 23 down is tens of hours, units of hours, tens of minutes, units of minutes, tens of seconds, units of seconds, 4 bits each. Load has priority over a one-second advance in the same cycle.
- R6: Outside reset exactly one bit of `dig_en` is high. Bit 0 is tens of hours, bit 1 units of hours, bit 2 tens of minutes, bit 3 units of minutes, bit 4 tens of seconds and bit 5 units of seconds. The active bit moves from bit 0 up to bit 5 and back to bit 0, one step every `SCAN_DIV` system clocks.
- R7: `seg` is active high with bit 0 = a through bit 6 = g. It carries 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F for digits 0 to 9 and 0x00 for any non-decimal code. It always shows the digit selected by the active `dig_en` bit.
- R8: While `rst` is high (synchronous, active high), `dig_en` and `seg` are all zero. After reset the time reads 00:00:00 and the prescaler count is zero.
- R9: `tick_in` and `sync_in` act only on rising edges. A level held high for many system clocks counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Line-rate timebase tick (asynchronous) |
| sync_in | input | 1 | Once-per-second alignment reference (asynchronous) |
| load_valid | input | 1 | One-cycle strobe that writes `load_time` |
| load_time | input | 24 | Six BCD digits to load, tens of hours in bits 23:20 |
| pps_out | output | 1 | One-cycle pulse for each one-second advance |
| dig_en | output | 6 | One-hot digit enable, bit 0 = tens of hours |
| seg | output | 7 | Shared segment lines, bit 0 = a, active high |

## Verification
The counter is tried with random valid start times followed by random tick bursts that span several seconds. This separates a prescaler that divides by the wrong ratio, or that loses its phase across a load, from a correct one. Directed starts at 00:00:59, 00:59:59, 09:59:59 and 23:59:59 each exercise a different carry depth, and a load of every decimal digit checks each segment pattern through the scanned display. A sync pulse in mid-count followed by 49 and then 50 ticks shows whether the prescaler is cleared while the digits are left alone. A tick held high at the 50th count shows whether edges or levels are counted.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int DIGITS = 6;
  localparam int SEG_W  = 7;

  typedef logic [3:0] bcd_t;

  // Packed so that hr_t occupies bits 23:20 and sc_u bits 3:0.
  typedef struct packed {
    bcd_t hr_t;
    bcd_t hr_u;
    bcd_t mn_t;
    bcd_t mn_u;
    bcd_t sc_t;
    bcd_t sc_u;
  } tod_t;

  // Active-high pattern, bit 0 = a ... bit 6 = g.
  function automatic logic [SEG_W-1:0] seg_encode(bcd_t d);
    logic [SEG_W-1:0] p;
    case (d)
      4'd0:    p = 7'h3F;
      4'd1:    p = 7'h06;
      4'd2:    p = 7'h5B;
      4'd3:    p = 7'h4F;
      4'd4:    p = 7'h66;
      4'd5:    p = 7'h6D;
      4'd6:    p = 7'h7D;
      4'd7:    p = 7'h07;
      4'd8:    p = 7'h7F;
      4'd9:    p = 7'h6F;
      default: p = 7'h00;
    endcase
    return p;
  endfunction

  // Increment one decimal digit that wraps after 'top'; 'wrap' flags the carry.
  function automatic bcd_t bcd_inc(bcd_t d, bcd_t top, output logic wrap);
    if (d >= top) begin
      wrap = 1'b1;
      return 4'd0;
    end
    wrap = 1'b0;
    return d + 4'd1;
  endfunction

  // One-second advance of the whole time of day, 24-hour wrap.
  function automatic tod_t tod_advance(tod_t t);
    tod_t n;
    logic c;
    n = t;
    c = 1'b0;
    n.sc_u = bcd_inc(t.sc_u, 4'd9, c);
    if (c) n.sc_t = bcd_inc(t.sc_t, 4'd5, c);
    if (c) n.mn_u = bcd_inc(t.mn_u, 4'd9, c);
    if (c) n.mn_t = bcd_inc(t.mn_t, 4'd5, c);
    if (c) begin
      if (t.hr_t == 4'd2 && t.hr_u == 4'd3) begin
        n.hr_t = 4'd0;
        n.hr_u = 4'd0;
      end else begin
        n.hr_u = bcd_inc(t.hr_u, 4'd9, c);
        if (c) n.hr_t = t.hr_t + 4'd1;
      end
    end
    return n;
  endfunction

  // Digit picked by scan index: 0 = tens of hours ... 5 = units of seconds.
  function automatic bcd_t tod_digit(tod_t t, int unsigned idx);
    logic [4*DIGITS-1:0] flat;
    flat = t;
    return flat[4*DIGITS-1-4*idx -: 4];
  endfunction

endpackage

// File: rtl/tod_edge_sync.sv
module tod_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              held;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) held <= 1'b0;
    else     held <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~held;

endmodule

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  output logic sec_pulse,
  output logic pps_q
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  assign sec_pulse = tick & ~clear & (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      pps_q <= 1'b0;
    end else begin
      pps_q <= sec_pulse;
      if (clear || sec_pulse) phase <= '0;
      else if (tick)          phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/tod_time_counter.sv
module tod_time_counter
  import tod_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  tod_t load_val,
  input  logic step,
  output tod_t time_q
);

  always_ff @(posedge clk) begin
    if (rst)       time_q <= '0;
    else if (load) time_q <= load_val;
    else if (step) time_q <= tod_advance(time_q);
  end

endmodule

// File: rtl/tod_scan.sv
module tod_scan
  import tod_pkg::*;
#(
  parameter int NDIG     = DIGITS,
  parameter int SCAN_DIV = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  tod_t             time_now,
  output logic [NDIG-1:0]  dig_en,
  output logic [SEG_W-1:0] seg
);

  localparam int DW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam int IW = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(SCAN_DIV - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NDIG - 1);

  logic [DW-1:0]   div_cnt;
  logic [IW-1:0]   idx;
  logic            scan_step;
  logic [NDIG-1:0] en_next;

  assign scan_step = (div_cnt == DIV_LAST);

  always_comb begin
    en_next      = '0;
    en_next[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      idx     <= '0;
    end else begin
      div_cnt <= scan_step ? '0 : div_cnt + 1'b1;
      if (scan_step) idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
    end
  end

  // Enable and pattern are registered together so they always match.
  always_ff @(posedge clk) begin
    if (rst) begin
      dig_en <= '0;
      seg    <= '0;
    end else begin
      dig_en <= en_next;
      seg    <= seg_encode(tod_digit(time_now, idx));
    end
  end

endmodule

// File: rtl/tod_display_clock.sv
module tod_display_clock
  import tod_pkg::*;
#(
  parameter int TICKS_PER_SEC = 50,
  parameter int SCAN_DIV      = 1000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_in,
  input  logic                sync_in,
  input  logic                load_valid,
  input  logic [4*DIGITS-1:0] load_time,
  output logic                pps_out,
  output logic [DIGITS-1:0]   dig_en,
  output logic [SEG_W-1:0]    seg
);

  // Named internal events, observed by the bound checker.
  logic tick_evt;
  logic sync_evt;
  logic prescale_clr;
  logic sec_pulse;
  tod_t time_now;

  tod_edge_sync #(.STAGES(SYNC_STAGES)) u_tick_sync (
    .clk (clk), .rst (rst), .din (tick_in), .rise (tick_evt)
  );

  tod_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk (clk), .rst (rst), .din (sync_in), .rise (sync_evt)
  );

  assign prescale_clr = sync_evt | load_valid;

  tod_prescaler #(.DIV(TICKS_PER_SEC)) u_prescale (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_evt),
    .clear     (prescale_clr),
    .sec_pulse (sec_pulse),
    .pps_q     (pps_out)
  );

  tod_time_counter u_time (
    .clk      (clk),
    .rst      (rst),
    .load     (load_valid),
    .load_val (tod_t'(load_time)),
    .step     (sec_pulse),
    .time_q   (time_now)
  );

  tod_scan #(.NDIG(DIGITS), .SCAN_DIV(SCAN_DIV)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .time_now (time_now),
    .dig_en   (dig_en),
    .seg      (seg)
  );

endmodule

// File: rtl/tod_clock_checker.sv
module tod_clock_checker #(
  parameter int TICKS_PER_SEC = 50
) (
  input logic        clk,
  input logic        rst,
  input logic        tick_evt,
  input logic        sync_evt,
  input logic        load_valid,
  input logic [23:0] load_time,
  input logic        sec_pulse,
  input logic [23:0] time_now,
  input logic        pps_out,
  input logic [5:0]  dig_en
);

  localparam int TW = $clog2(TICKS_PER_SEC + 1);

  logic [TW-1:0] ticks_seen;

  always_ff @(posedge clk) begin
    if (rst || sync_evt || load_valid || sec_pulse) ticks_seen <= '0;
    else if (tick_evt)                              ticks_seen <= ticks_seen + 1'b1;
  end

  p_full_count_r1: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |-> (tick_evt && ticks_seen == TW'(TICKS_PER_SEC - 1)));

  p_pps_single_r1: assert property (@(posedge clk) disable iff (rst)
    pps_out |=> !pps_out);

  p_sync_keeps_time_r2: assert property (@(posedge clk) disable iff (rst)
    (sync_evt && !load_valid) |=> $stable(time_now));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !load_valid && time_now[7:0] == 8'h59) |=> time_now[7:0] == 8'h00);

  p_day_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !load_valid && time_now == 24'h235959) |=> time_now == 24'h000000);

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    load_valid |=> time_now == $past(load_time));

  p_one_digit_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $onehot(dig_en));

  p_scan_rotate_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(dig_en) != 6'd0 && dig_en != $past(dig_en))
      |-> dig_en == {$past(dig_en[4:0]), $past(dig_en[5])});

  p_dark_in_reset_r8: assert property (@(posedge clk)
    rst |=> dig_en == 6'd0);

endmodule

bind tod_display_clock tod_clock_checker #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .tick_evt   (tick_evt),
  .sync_evt   (sync_evt),
  .load_valid (load_valid),
  .load_time  (load_time),
  .sec_pulse  (sec_pulse),
  .time_now   (time_now),
  .pps_out    (pps_out),
  .dig_en     (dig_en)
);

// File: tb/tb_tod_display_clock.sv
module tb_tod_display_clock;

  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 50;
  localparam int SDIV       = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_in = 1'b0;
  logic        sync_in = 1'b0;
  logic        load_valid = 1'b0;
  logic [23:0] load_time = '0;
  logic        pps_out;
  logic [5:0]  dig_en;
  logic [6:0]  seg;

  int checks = 0;
  int failures = 0;
  int pps_seen = 0;
  int exp_pps = 0;
  int exp_secs = 0;
  int phase = 0;
  int onehot_bad = 0;
  int order_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_display_clock #(.TICKS_PER_SEC(TPS), .SCAN_DIV(SDIV), .SYNC_STAGES(2)) dut (
    .clk (clk), .rst (rst), .tick_in (tick_in), .sync_in (sync_in),
    .load_valid (load_valid), .load_time (load_time),
    .pps_out (pps_out), .dig_en (dig_en), .seg (seg)
  );

  always @(negedge clk) if (!rst && pps_out) pps_seen++;

  function automatic logic [6:0] bench_pattern(int d);
    logic [6:0] lut [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                             7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return lut[d];
  endfunction

  function automatic logic [3:0] bench_decode(logic [6:0] p);
    for (int d = 0; d < 10; d++) if (bench_pattern(d) == p) return 4'(d);
    return 4'hF;
  endfunction

  function automatic logic [23:0] secs_to_bcd(int s);
    int h = s / 3600;
    int m = (s / 60) % 60;
    int c = s % 60;
    return {4'(h/10), 4'(h%10), 4'(m/10), 4'(m%10), 4'(c/10), 4'(c%10)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Walks two full scans and rebuilds the six digits from the pins.
  task automatic read_display(output logic [23:0] v);
    logic [5:0] prev = '0;
    v = 24'hFFFFFF;
    repeat (6 * SDIV * 2 + 2) begin
      @(negedge clk);
      if ($countones(dig_en) != 1) onehot_bad++;
      else begin
        for (int i = 0; i < 6; i++)
          if (dig_en[i]) v[23-4*i -: 4] = bench_decode(seg);
        if (prev != 6'd0 && dig_en != prev && dig_en != {prev[4:0], prev[5]}) order_bad++;
        prev = dig_en;
      end
    end
  endtask

  task automatic bump_phase();
    phase++;
    if (phase == TPS) begin
      phase = 0;
      exp_secs = (exp_secs + 1) % 86400;
      exp_pps++;
    end
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      tick_in = 1'b1;
      repeat (3) @(negedge clk);
      tick_in = 1'b0;
      repeat (3) @(negedge clk);
      bump_phase();
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_sync();
    sync_in = 1'b1;
    repeat (3) @(negedge clk);
    sync_in = 1'b0;
    repeat (4) @(negedge clk);
    phase = 0;
  endtask

  task automatic load_secs(int s);
    @(negedge clk);
    load_valid = 1'b1;
    load_time = secs_to_bcd(s);
    @(negedge clk);
    load_valid = 1'b0;
    exp_secs = s;
    phase = 0;
  endtask

  task automatic check_time(string req);
    logic [23:0] v;
    read_display(v);
    chk(req, {8'h0, v}, {8'h0, secs_to_bcd(exp_secs)});
    chk({req, " pps count"}, pps_seen, exp_pps);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [23:0] v;
    int unsigned seed;
    seed = $urandom(32'h5EC0_0D01);

    // R8: dark while in reset
    repeat (4) @(negedge clk);
    chk("R8 dig_en in reset", {26'h0, dig_en}, 32'h0);
    chk("R8 seg in reset", {25'h0, seg}, 32'h0);
    rst = 1'b0;
    check_time("R8 time after reset");

    // R1: first second from reset
    ticks(49);
    check_time("R1 49 ticks no advance");
    ticks(1);
    check_time("R1 50th tick advances");

    // R7: every decimal pattern through the scan (raw load, no ticks)
    @(negedge clk); load_valid = 1'b1; load_time = 24'h012345; @(negedge clk); load_valid = 1'b0;
    read_display(v);
    chk("R7 digits 0-5", {8'h0, v}, 32'h012345);
    @(negedge clk); load_valid = 1'b1; load_time = 24'h678901; @(negedge clk); load_valid = 1'b0;
    read_display(v);
    chk("R7 digits 6-9", {8'h0, v}, 32'h678901);

    // R3 / R4: carry chain corners
    load_secs(59);          ticks(TPS); check_time("R3 seconds wrap 00:00:59");
    load_secs(59*60+59);    ticks(TPS); check_time("R3 minutes wrap 00:59:59");
    load_secs(9*3600+3599); ticks(TPS); check_time("R4 hour carry 09:59:59");
    load_secs(86399);       ticks(TPS); check_time("R4 day wrap 23:59:59");

    // R5: load clears prescaler mid-count
    load_secs(3600);
    ticks(30);
    load_secs(7200);
    ticks(49);
    check_time("R5 load restarts count at 49");
    ticks(1);
    check_time("R5 load restarts count at 50");

    // R2: sync clears prescaler, keeps time
    load_secs(45296);
    ticks(30);
    pulse_sync();
    check_time("R2 sync keeps digits");
    ticks(49);
    check_time("R2 49 ticks after sync");
    ticks(1);
    check_time("R2 50 ticks after sync");

    // R9: a long-held level is one edge
    load_secs(100);
    ticks(49);
    tick_in = 1'b1;
    repeat (40) @(negedge clk);
    tick_in = 1'b0;
    repeat (6) @(negedge clk);
    bump_phase();
    check_time("R9 held tick counts once");
    ticks(1);
    check_time("R9 next edge only one tick");

    // R1 / R3 / R4: random starts and bursts
    for (int r = 0; r < 20; r++) begin
      load_secs(int'($urandom % 86400));
      ticks(int'($urandom % 160) + 1);
      check_time("R1 random burst");
    end

    chk("R6 one enable at a time", onehot_bad, 0);
    chk("R6 scan order", order_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule